// File: doc/BRIEF.md
# Instruction Reuse Buffer

This block is a memoization table that sits beside an execution unit. Each entry holds an opcode, the two operand values the instruction consumed, and the result it produced. When an instruction issues, the pipeline presents its opcode and operands as a lookup. If all three match a stored entry exactly, the block reports a hit and returns the stored result, and the pipeline can skip the execute step. If there is no match, the instruction executes normally and its result is written back through the insert port when it completes.

The storage stands for one half of a data cache array that has been lent to this purpose. It is organised as a 4-way set-associative table. The set index is a hash of the key: the XOR of the low opcode bits with the low bits of both operands. Replacement is least-recently-used within a set. A lookup and an insert that arrive in the same cycle are merged, so the lookup sees the entry being written. A global flush clears the whole table in one cycle, which is what happens when the array is handed back to the cache. Two free-running counters record lookup hits and misses.

Top module: `reuse_buffer`

## Requirements
- R1: After reset the table holds no valid entries, both counters read zero and `rsp_valid` is low.
- R2: A lookup presented in cycle t gives exactly one response in cycle t+1 (`rsp_valid` high). `rsp_valid` is low in any cycle that follows a cycle with no lookup.
- R3: A lookup hits only when a valid entry holds the same opcode (all 8 bits), the same operand A (all 32 bits) and the same operand B (all 32 bits). On a hit `rsp_result` is that entry's result. On a miss `rsp_hit` is 0 and `rsp_result` is 0.
- R4: The set for a key is `opcode[3:0] ^ op_a[3:0] ^ op_b[3:0]`. Keys with different fields but the same set value compete for the same 4 ways.
- R5: An insert whose key is not already in its set goes into the lowest-numbered invalid way of that set. If all four ways are valid, it replaces the least recently used way.
- R6: A lookup hit and an insert both make the touched entry the most recently used in its set. When a lookup hit and an insert target the same set in one cycle, the lookup's touch is applied first and the victim is chosen after it.
- R7: An insert whose key already matches a valid entry in its set overwrites that entry's result and allocates no other way.
- R8: When a lookup and an insert carry the same key in the same cycle, the lookup hits and returns the insert's result.
- R9: `flush` clears every entry in one cycle. A lookup in a flush cycle misses, an insert in a flush cycle is dropped, and every lookup after the flush misses until new inserts arrive.
- R10: `hit_count` rises by one for each hit response and `miss_count` rises by one for each miss response. Both are 16 bits wide and wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request |
| lk_opcode | input | 8 | Lookup opcode |
| lk_op_a | input | 32 | Lookup operand A |
| lk_op_b | input | 32 | Lookup operand B |
| rsp_valid | output | 1 | Lookup response valid, one cycle after the request |
| rsp_hit | output | 1 | Lookup matched a stored entry |
| rsp_result | output | 32 | Stored result on a hit, zero otherwise |
| ins_valid | input | 1 | Insert request for a completed instruction |
| ins_opcode | input | 8 | Insert opcode |
| ins_op_a | input | 32 | Insert operand A |
| ins_op_b | input | 32 | Insert operand B |
| ins_result | input | 32 | Result to memoize |
| flush | input | 1 | Invalidate the whole table |
| hit_count | output | 16 | Number of hit responses, wrapping |
| miss_count | output | 16 | Number of miss responses, wrapping |

## Verification
A corrupted valid bit or key shows up as a wrong `rsp_hit` on the next lookup of that key, one cycle after the lookup. A corrupted recency order stays hidden until the set overflows. It then shows as the wrong key missing after a fifth insert into the set, so the bench fills sets and probes each resident key. Forwarding and flush faults affect the response to the very lookup that shares the cycle, so the bench issues those lookups together with inserts and flushes. It also tracks both counters against its own model on every cycle.

// File: rtl/irb_pkg.sv
package irb_pkg;
    localparam int OPC_W  = 8;
    localparam int DATA_W = 32;
    localparam int SET_W  = 4;
    localparam int SETS   = 1 << SET_W;
    localparam int WAYS   = 4;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int CNT_W  = 16;

    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [SET_W-1:0]  set_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        data_t            a;
        data_t            b;
    } key_t;

    typedef struct packed {
        logic  vld;
        key_t  key;
        data_t res;
    } entry_t;

    // Per-set recency: one age per way, 0 = most recent, WAYS-1 = oldest.
    typedef way_t [WAYS-1:0] age_vec_t;

    function automatic set_t set_of(key_t k);
        return k.opc[SET_W-1:0] ^ k.a[SET_W-1:0] ^ k.b[SET_W-1:0];
    endfunction

    function automatic age_vec_t ages_init();
        age_vec_t r;
        for (int j = 0; j < WAYS; j++) r[j] = way_t'(j);
        return r;
    endfunction

    function automatic age_vec_t touch(age_vec_t ag, way_t w);
        age_vec_t r;
        r = ag;
        for (int j = 0; j < WAYS; j++) begin
            if (ag[j] < ag[w]) r[j] = ag[j] + 1'b1;
        end
        r[w] = '0;
        return r;
    endfunction

    function automatic way_t pick_victim(age_vec_t ag, logic [WAYS-1:0] vld);
        way_t v;
        v = '0;
        for (int j = 0; j < WAYS; j++) begin
            if (ag[j] == way_t'(WAYS - 1)) v = way_t'(j);
        end
        for (int j = WAYS - 1; j >= 0; j--) begin
            if (!vld[j]) v = way_t'(j);
        end
        return v;
    endfunction
endpackage

// File: rtl/irb_store.sv
module irb_store
    import irb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic                  we,
    input  set_t                  wr_set,
    input  way_t                  wr_way,
    input  key_t                  wr_key,
    input  data_t                 wr_res,
    input  set_t                  rd_set_a,
    input  set_t                  rd_set_b,
    output entry_t [WAYS-1:0]     rows_a,
    output entry_t [WAYS-1:0]     rows_b
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0] vld_q;
        key_t            key_q [SETS];
        data_t           res_q [SETS];
        logic            wr_here;

        assign wr_here = we && (wr_way == way_t'(w));

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                vld_q <= '0;
            end else if (wr_here) begin
                vld_q[wr_set] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_here) begin
                key_q[wr_set] <= wr_key;
                res_q[wr_set] <= wr_res;
            end
        end

        assign rows_a[w].vld = vld_q[rd_set_a];
        assign rows_a[w].key = key_q[rd_set_a];
        assign rows_a[w].res = res_q[rd_set_a];
        assign rows_b[w].vld = vld_q[rd_set_b];
        assign rows_b[w].key = key_q[rd_set_b];
        assign rows_b[w].res = res_q[rd_set_b];

        // R9: one cycle after a flush this way is empty in every set
        p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
            flush |=> (vld_q == '0));
    end
endmodule

// File: rtl/irb_match.sv
module irb_match
    import irb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  entry_t [WAYS-1:0] rows,
    input  key_t              key,
    output logic              hit,
    output way_t              way,
    output data_t             res
);
    logic [WAYS-1:0] hv;

    always_comb begin
        hit = 1'b0;
        way = '0;
        res = '0;
        for (int j = 0; j < WAYS; j++) begin
            hv[j] = rows[j].vld && (rows[j].key == key);
            if (hv[j]) begin
                hit = 1'b1;
                way = way_t'(j);
                res = rows[j].res;
            end
        end
    end

    // R7: a key never sits in two ways of one set
    p_unique_key_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hv));
endmodule

// File: rtl/irb_lru.sv
module irb_lru
    import irb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_touch,
    input  set_t             lk_set,
    input  way_t             lk_way,
    input  logic             ins_en,
    input  set_t             ins_set,
    input  logic [WAYS-1:0]  ins_vld,
    input  logic             ins_dup,
    input  way_t             ins_dup_way,
    output way_t             ins_way
);
    age_vec_t age_q [SETS];
    age_vec_t base;
    way_t     victim;

    always_comb begin
        base    = (lk_touch && lk_set == ins_set) ? touch(age_q[ins_set], lk_way)
                                                  : age_q[ins_set];
        victim  = pick_victim(base, ins_vld);
        ins_way = ins_dup ? ins_dup_way : victim;
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) begin
            if (rst) begin
                age_q[s] <= ages_init();
            end else if (ins_en && ins_set == set_t'(s)) begin
                age_q[s] <= touch(base, ins_way);
            end else if (lk_touch && lk_set == set_t'(s)) begin
                age_q[s] <= touch(age_q[s], lk_way);
            end
        end
    end

    for (genvar s = 0; s < SETS; s++) begin : g_chk
        logic [WAYS-1:0] seen;
        always_comb begin
            seen = '0;
            for (int j = 0; j < WAYS; j++) seen[age_q[s][j]] = 1'b1;
        end
        // R6: the ages of a set always form a full recency order
        p_age_order_r6: assert property (@(posedge clk) disable iff (rst)
            $countones(seen) == WAYS);
    end
endmodule

// File: rtl/reuse_buffer.sv
module reuse_buffer
    import irb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [OPC_W-1:0]  lk_opcode,
    input  logic [DATA_W-1:0] lk_op_a,
    input  logic [DATA_W-1:0] lk_op_b,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_result,
    input  logic              ins_valid,
    input  logic [OPC_W-1:0]  ins_opcode,
    input  logic [DATA_W-1:0] ins_op_a,
    input  logic [DATA_W-1:0] ins_op_b,
    input  logic [DATA_W-1:0] ins_result,
    input  logic              flush,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    key_t              lk_key, ins_key;
    set_t              lk_set, ins_set;
    entry_t [WAYS-1:0] rows_lk, rows_ins;
    logic              arr_hit, dup_hit, fwd, lk_hit_now, lk_touch, ins_en;
    way_t              arr_way, dup_way, ins_way;
    data_t             arr_res, dup_res, lk_res;
    logic [WAYS-1:0]   ins_vld;

    assign lk_key  = '{opc: lk_opcode,  a: lk_op_a,  b: lk_op_b};
    assign ins_key = '{opc: ins_opcode, a: ins_op_a, b: ins_op_b};
    assign lk_set  = set_of(lk_key);
    assign ins_set = set_of(ins_key);

    irb_store u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .we       (ins_en),
        .wr_set   (ins_set),
        .wr_way   (ins_way),
        .wr_key   (ins_key),
        .wr_res   (ins_result),
        .rd_set_a (lk_set),
        .rd_set_b (ins_set),
        .rows_a   (rows_lk),
        .rows_b   (rows_ins)
    );

    irb_match u_lk_match (
        .clk (clk), .rst (rst), .rows (rows_lk), .key (lk_key),
        .hit (arr_hit), .way (arr_way), .res (arr_res)
    );

    irb_match u_ins_match (
        .clk (clk), .rst (rst), .rows (rows_ins), .key (ins_key),
        .hit (dup_hit), .way (dup_way), .res (dup_res)
    );

    always_comb begin
        for (int j = 0; j < WAYS; j++) ins_vld[j] = rows_ins[j].vld;
    end

    assign ins_en     = ins_valid && !flush;
    assign fwd        = lk_valid && ins_valid && (lk_key == ins_key);
    assign lk_hit_now = lk_valid && !flush && (fwd || arr_hit);
    assign lk_res     = fwd ? ins_result : arr_res;
    assign lk_touch   = lk_valid && !flush && arr_hit && !fwd;

    irb_lru u_lru (
        .clk         (clk),
        .rst         (rst),
        .lk_touch    (lk_touch),
        .lk_set      (lk_set),
        .lk_way      (arr_way),
        .ins_en      (ins_en),
        .ins_set     (ins_set),
        .ins_vld     (ins_vld),
        .ins_dup     (dup_hit),
        .ins_dup_way (dup_way),
        .ins_way     (ins_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_result <= '0;
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            rsp_valid  <= lk_valid;
            rsp_hit    <= lk_hit_now;
            rsp_result <= lk_hit_now ? lk_res : '0;
            if (lk_valid && lk_hit_now)  hit_count  <= hit_count + 1'b1;
            if (lk_valid && !lk_hit_now) miss_count <= miss_count + 1'b1;
        end
    end

    // R2: every lookup is answered on the next cycle, and only then
    p_rsp_next_r2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);
    p_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);
    // R8: same-key insert is visible to the lookup of the same cycle
    p_forward_r8: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && ins_valid && !flush && lk_opcode == ins_opcode &&
         lk_op_a == ins_op_a && lk_op_b == ins_op_b)
        |=> (rsp_hit && rsp_result == $past(ins_result)));
    // R9: nothing hits while the table is being cleared
    p_flush_miss_r9: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && flush) |=> !rsp_hit);
    // R10: a hit response comes with exactly one counter step
    p_hit_count_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> (hit_count == CNT_W'($past(hit_count) + 1'b1)));
    p_miss_count_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (miss_count == CNT_W'($past(miss_count) + 1'b1)));
    // R3: a miss carries a zero result
    p_miss_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_result == '0));
endmodule

// File: tb/reuse_buffer_tb.sv
`timescale 1ns/1ps
module reuse_buffer_tb;
    import irb_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0, ins_valid = 1'b0, flush = 1'b0;
    logic [7:0]  lk_opcode = '0, ins_opcode = '0;
    logic [31:0] lk_op_a = '0, lk_op_b = '0, ins_op_a = '0, ins_op_b = '0, ins_result = '0;
    logic        rsp_valid, rsp_hit;
    logic [31:0] rsp_result;
    logic [15:0] hit_count, miss_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    reuse_buffer u_dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_opcode(lk_opcode), .lk_op_a(lk_op_a), .lk_op_b(lk_op_b),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_result(rsp_result),
        .ins_valid(ins_valid), .ins_opcode(ins_opcode), .ins_op_a(ins_op_a),
        .ins_op_b(ins_op_b), .ins_result(ins_result), .flush(flush),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    // ---------------- reference model ----------------
    bit          m_vld [16][4];
    key_t        m_key [16][4];
    logic [31:0] m_res [16][4];
    int          m_ord [16][4];   // recency list, most recent first
    logic [15:0] m_hits = '0, m_miss = '0;

    function automatic int hash_of(key_t k);
        return int'((k.opc[3:0] ^ k.a[3:0] ^ k.b[3:0]));
    endfunction

    function automatic void m_reset();
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++) begin
                m_vld[s][w] = 1'b0;
                m_ord[s][w] = w;
            end
        m_hits = '0;
        m_miss = '0;
    endfunction

    function automatic void m_touch(int s, int w);
        int p = 0;
        for (int i = 0; i < 4; i++) if (m_ord[s][i] == w) p = i;
        for (int i = p; i > 0; i--) m_ord[s][i] = m_ord[s][i-1];
        m_ord[s][0] = w;
    endfunction

    function automatic int m_find(int s, key_t k);
        for (int w = 0; w < 4; w++) if (m_vld[s][w] && m_key[s][w] == k) return w;
        return -1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock cycle: drive, advance model, sample after the edge.
    task automatic step(input logic lv, input key_t lk, input logic iv, input key_t ik,
                        input logic [31:0] ir, input logic fl, input string tag);
        bit          e_hit = 1'b0;
        logic [31:0] e_res = '0;
        int          s, h, si, w;
        @(negedge clk);
        lk_valid = lv; lk_opcode = lk.opc; lk_op_a = lk.a; lk_op_b = lk.b;
        ins_valid = iv; ins_opcode = ik.opc; ins_op_a = ik.a; ins_op_b = ik.b;
        ins_result = ir; flush = fl;
        if (fl) begin
            for (int a = 0; a < 16; a++) for (int b = 0; b < 4; b++) m_vld[a][b] = 1'b0;
        end else begin
            s = hash_of(lk);
            h = m_find(s, lk);
            if (lv && iv && ik == lk) begin
                e_hit = 1'b1; e_res = ir;
            end else if (lv && h >= 0) begin
                e_hit = 1'b1; e_res = m_res[s][h]; m_touch(s, h);
            end
            if (iv) begin
                si = hash_of(ik);
                w = m_find(si, ik);
                if (w < 0) begin
                    w = m_ord[si][3];
                    for (int j = 3; j >= 0; j--) if (!m_vld[si][j]) w = j;
                end
                m_vld[si][w] = 1'b1; m_key[si][w] = ik; m_res[si][w] = ir;
                m_touch(si, w);
            end
        end
        if (lv) begin
            if (e_hit) m_hits++; else m_miss++;
        end
        @(posedge clk);
        #1;
        chk("R2", {31'd0, rsp_valid}, {31'd0, lv}, "rsp_valid");
        if (lv) begin
            chk(tag, {31'd0, rsp_hit}, {31'd0, e_hit}, "rsp_hit");
            chk(tag, rsp_result, e_res, "rsp_result");
        end
        chk("R10", {16'd0, hit_count}, {16'd0, m_hits}, "hit_count");
        chk("R10", {16'd0, miss_count}, {16'd0, m_miss}, "miss_count");
    endtask

    function automatic key_t mk(logic [7:0] o, logic [31:0] a, logic [31:0] b);
        key_t k;
        k.opc = o; k.a = a; k.b = b;
        return k;
    endfunction

    // Random key that hashes to set s (R4 formula)
    function automatic key_t key_in_set(int s);
        key_t k;
        k.opc = 8'($urandom);
        k.a   = $urandom;
        k.b   = $urandom;
        k.b[3:0] = 4'(s) ^ k.opc[3:0] ^ k.a[3:0];
        return k;
    endfunction

    task automatic look(input key_t k, input string tag);
        step(1'b1, k, 1'b0, '0, '0, 1'b0, tag);
    endtask

    task automatic put(input key_t k, input logic [31:0] r, input string tag);
        step(1'b0, '0, 1'b1, k, r, 1'b0, tag);
    endtask

    key_t z = '0;

    initial begin
        key_t k0, k1, k2, k3, k4, kx;
        logic [31:0] pool [8];
        void'($urandom(32'd20240611));
        pool[0] = 32'h0; pool[1] = 32'h1; pool[2] = 32'h2; pool[3] = 32'h3;
        pool[4] = 32'h10; pool[5] = 32'h11; pool[6] = 32'hFFFF_FFFF; pool[7] = 32'h8000_0000;
        m_reset();
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", {31'd0, rsp_valid}, 32'd0, "rsp_valid in reset");
        chk("R1", {16'd0, hit_count}, 32'd0, "hit_count in reset");
        chk("R1", {16'd0, miss_count}, 32'd0, "miss_count in reset");
        @(negedge clk); rst = 1'b0;
        step(1'b0, z, 1'b0, z, '0, 1'b0, "R2");
        look(mk(8'h12, 32'h5, 32'h9), "R1");

        // R3: exact match on all fields
        k0 = mk(8'h21, 32'hDEAD_0004, 32'h0000_0100);
        put(k0, 32'hCAFE_0001, "R3");
        look(k0, "R3");
        look(mk(8'h21, 32'hDEAD_0004, 32'h8000_0100), "R3");
        look(mk(8'hA1, 32'hDEAD_0004, 32'h0000_0100), "R3");
        look(mk(8'h21, 32'h5EAD_0004, 32'h0000_0100), "R3");

        // R8: same-cycle forwarding
        k1 = mk(8'h33, 32'h77, 32'h91);
        step(1'b1, k1, 1'b1, k1, 32'h1234_5678, 1'b0, "R8");
        look(k1, "R8");

        // R4/R5/R6: five keys with mixed fields, all hashing to set 9
        k0 = key_in_set(9); k1 = key_in_set(9); k2 = key_in_set(9);
        k3 = key_in_set(9); k4 = key_in_set(9);
        put(k0, 32'hA0, "R5"); put(k1, 32'hA1, "R5");
        put(k2, 32'hA2, "R5"); put(k3, 32'hA3, "R5");
        look(k0, "R6");
        put(k4, 32'hA4, "R4");
        look(k1, "R5");
        look(k0, "R6"); look(k2, "R4"); look(k3, "R4"); look(k4, "R4");

        // R6: lookup touch and insert in the same set and cycle
        kx = key_in_set(9);
        step(1'b1, k2, 1'b1, kx, 32'hB0, 1'b0, "R6");
        look(k2, "R6"); look(kx, "R6"); look(k3, "R6"); look(k0, "R6"); look(k4, "R6");

        // R7: rewrite of an existing key
        put(k2, 32'hB2, "R7");
        look(k2, "R7"); look(kx, "R7"); look(k4, "R7"); look(k0, "R7");

        // R9: flush with a same-cycle lookup and insert
        k3 = mk(8'h44, 32'h4, 32'h4);
        step(1'b1, k2, 1'b1, k3, 32'hC3, 1'b1, "R9");
        look(k2, "R9"); look(k3, "R9"); look(k4, "R9");
        put(k3, 32'hC4, "R9");
        look(k3, "R9");

        // Random traffic over a small key space
        for (int i = 0; i < 4000; i++) begin
            key_t rl, ri;
            bit   lv, iv, fl;
            rl = mk(8'($urandom_range(0, 3)), pool[$urandom_range(0, 7)], pool[$urandom_range(0, 7)]);
            ri = mk(8'($urandom_range(0, 3)), pool[$urandom_range(0, 7)], pool[$urandom_range(0, 7)]);
            if ($urandom_range(0, 9) < 2) ri = rl;
            lv = ($urandom_range(0, 9) < 7);
            iv = ($urandom_range(0, 9) < 4);
            fl = ($urandom_range(0, 199) == 0);
            step(lv, rl, iv, ri, $urandom, fl, "R3");
        end
        step(1'b0, z, 1'b0, z, '0, 1'b0, "R2");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule